// File: doc/BRIEF.md
# DRAM Address Latch and Row/Column Multiplexer

This block sits between a host address bus and the address pins of a DRAM array. It captures a bank, row and column address when the host presents a latch strobe. It then drives one shared DRAM address bus. A phase select picks the row half or the column half of that bus. When the phase select returns to the row half, an access to another bank can start while the strobes for the current one finish. While a refresh is in progress, the bus carries the refresh row address instead of the latched values.

For sequential static-column or page-mode transfers, a column-increment input steps the held column address by one on each clock edge. The count wraps inside the configured column width and never carries into the row. The same input is left alone while a refresh runs, because it then serves as the refresh-extend control. A mode bit makes the latches transparent, so the bus follows the host inputs directly. The address width is a parameter of 9, 10 or 11 bits. The DRAM bus is always 11 bits wide, and any bits above the configured width are driven low.

Top module: `dram_addr_mux`

## Requirements
- R1: While reset (rst_n low) is asserted, the held row, column and bank are cleared, so with rfip low and fall_thru low both dram_addr and bank_q read zero.
- R2: With fall_thru low, a rising edge where latch_en is high captures row_in, col_in and bank_in.
- R3: With fall_thru low and latch_en low, changes on row_in, col_in and bank_in do not reach dram_addr or bank_q.
- R4: With rfip low, col_phase = 0 puts the row address on dram_addr and col_phase = 1 puts the column address on dram_addr.
- R5: With fall_thru low, rfip low and latch_en low, each rising edge that samples col_inc high adds exactly one to the held column address.
- R6: A column increment from the all-ones value of the configured width gives zero, and the held row address does not change.
- R7: While rfip is high, dram_addr equals rf_addr, whatever the state of col_phase.
- R8: While rfip is high, col_inc has no effect on the held column address.
- R9: With fall_thru high, dram_addr follows row_in or col_in (as col_phase selects) in the same cycle, and bank_q equals bank_in.
- R10: The bits of dram_addr at and above position ADDR_W are always zero.
- R11: When latch_en and col_inc are both high at the same edge, the captured col_in wins and no increment is applied.
- R12: With fall_thru low, bank_q holds the bank captured at the last strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| row_in | input | ADDR_W | Host row address |
| col_in | input | ADDR_W | Host column address |
| bank_in | input | BANK_W | Host bank select |
| latch_en | input | 1 | Capture strobe for row, column and bank |
| col_phase | input | 1 | 0 selects the row half, 1 selects the column half |
| rfip | input | 1 | Refresh in progress |
| rf_addr | input | ADDR_W | Refresh row address |
| col_inc | input | 1 | Column increment (acts as refresh extend during refresh) |
| fall_thru | input | 1 | Transparent latch mode |
| dram_addr | output | 11 | Multiplexed DRAM address |
| bank_q | output | BANK_W | Latched (or transparent) bank select |

## Verification
A held column that is wrong shows up on dram_addr in the first cycle where col_phase is high and rfip is low. A held row that is wrong shows up in the first cycle where col_phase is low. A missed increment, a doubled increment, or a carry that leaks into the row can therefore be seen one edge after the increment. An increment that wrongly slips through during refresh stays hidden behind rf_addr until rfip drops, and then shows at once as an off-by-one column. A wrong bank appears on bank_q immediately.

// File: rtl/dal_pkg.sv
package dal_pkg;
  localparam int DAL_OUT_W = 11;

  typedef enum logic {PH_ROW = 1'b0, PH_COL = 1'b1} dal_phase_e;

  // one-step column advance, wrapping inside a width of w bits
  function automatic logic [DAL_OUT_W-1:0] col_step(input logic [DAL_OUT_W-1:0] c,
                                                    input int w);
    logic [DAL_OUT_W-1:0] mask;
    mask = {DAL_OUT_W{1'b1}} >> (DAL_OUT_W - w);
    return (c + 1'b1) & mask;
  endfunction
endpackage

// File: rtl/dal_addr_latch.sv
module dal_addr_latch #(
  parameter int AW = 10,
  parameter int BW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] row_in,
  input  logic [AW-1:0] col_in,
  input  logic [BW-1:0] bank_in,
  input  logic          latch_en,
  input  logic          rfip,
  input  logic          col_inc,
  input  logic          fall_thru,
  output logic [AW-1:0] row_q,
  output logic [AW-1:0] col_q,
  output logic [BW-1:0] bank_q,
  output logic          cap_fire,
  output logic          inc_fire
);
  import dal_pkg::*;

  logic [AW-1:0] col_nx;

  // a capture outranks an increment at the same edge
  assign cap_fire = latch_en && !fall_thru;
  assign inc_fire = col_inc && !rfip && !fall_thru && !latch_en;
  assign col_nx   = AW'(col_step(DAL_OUT_W'(col_q), AW));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q  <= '0;
      col_q  <= '0;
      bank_q <= '0;
    end else if (cap_fire) begin
      row_q  <= row_in;
      col_q  <= col_in;
      bank_q <= bank_in;
    end else if (inc_fire) begin
      col_q  <= col_nx;
    end
  end
endmodule

// File: rtl/dal_out_mux.sv
module dal_out_mux #(
  parameter int AW    = 10,
  parameter int BW    = 2,
  parameter int OUT_W = 11
) (
  input  logic             fall_thru,
  input  logic             col_phase,
  input  logic             rfip,
  input  logic [AW-1:0]    row_in,
  input  logic [AW-1:0]    col_in,
  input  logic [BW-1:0]    bank_in,
  input  logic [AW-1:0]    row_q,
  input  logic [AW-1:0]    col_q,
  input  logic [BW-1:0]    bank_q,
  input  logic [AW-1:0]    rf_addr,
  output logic [OUT_W-1:0] dram_addr,
  output logic [BW-1:0]    bank_out
);
  import dal_pkg::*;

  logic [AW-1:0] row_eff, col_eff, sel;

  assign row_eff  = fall_thru ? row_in  : row_q;
  assign col_eff  = fall_thru ? col_in  : col_q;
  assign bank_out = fall_thru ? bank_in : bank_q;

  always_comb begin
    if (rfip)                          sel = rf_addr;
    else if (col_phase == 1'(PH_COL))  sel = col_eff;
    else                               sel = row_eff;
  end

  generate
    if (AW < OUT_W) begin : g_pad
      assign dram_addr = {{(OUT_W-AW){1'b0}}, sel};
    end else begin : g_full
      assign dram_addr = sel;
    end
  endgenerate
endmodule

// File: rtl/dram_addr_mux.sv
module dram_addr_mux #(
  parameter int ADDR_W = 10,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] row_in,
  input  logic [ADDR_W-1:0] col_in,
  input  logic [BANK_W-1:0] bank_in,
  input  logic              latch_en,
  input  logic              col_phase,
  input  logic              rfip,
  input  logic [ADDR_W-1:0] rf_addr,
  input  logic              col_inc,
  input  logic              fall_thru,
  output logic [10:0]       dram_addr,
  output logic [BANK_W-1:0] bank_q
);
  import dal_pkg::*;

  // internal events exposed for the bound checker
  logic [ADDR_W-1:0] lat_row, lat_col;
  logic [BANK_W-1:0] lat_bank;
  logic              cap_fire, inc_fire;

  dal_addr_latch #(.AW(ADDR_W), .BW(BANK_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .row_in(row_in), .col_in(col_in), .bank_in(bank_in),
    .latch_en(latch_en), .rfip(rfip), .col_inc(col_inc), .fall_thru(fall_thru),
    .row_q(lat_row), .col_q(lat_col), .bank_q(lat_bank),
    .cap_fire(cap_fire), .inc_fire(inc_fire)
  );

  dal_out_mux #(.AW(ADDR_W), .BW(BANK_W), .OUT_W(DAL_OUT_W)) u_mux (
    .fall_thru(fall_thru), .col_phase(col_phase), .rfip(rfip),
    .row_in(row_in), .col_in(col_in), .bank_in(bank_in),
    .row_q(lat_row), .col_q(lat_col), .bank_q(lat_bank), .rf_addr(rf_addr),
    .dram_addr(dram_addr), .bank_out(bank_q)
  );
endmodule

// File: rtl/dram_addr_mux_chk.sv
module dram_addr_mux_chk #(
  parameter int AW = 10,
  parameter int BW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] col_in,
  input logic [BW-1:0] bank_in,
  input logic          rfip,
  input logic [AW-1:0] rf_addr,
  input logic          fall_thru,
  input logic [10:0]   dram_addr,
  input logic [BW-1:0] bank_q,
  input logic [AW-1:0] lat_row,
  input logic [AW-1:0] lat_col,
  input logic [BW-1:0] lat_bank,
  input logic          cap_fire,
  input logic          inc_fire
);
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R3
  hold_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(!cap_fire) |-> $stable(lat_row) && $stable(lat_bank));
  // R5
  col_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(inc_fire) |-> lat_col == AW'($past(lat_col) + 1'b1));
  // R8
  rf_no_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(rfip && !cap_fire) |-> $stable(lat_col));
  // R11
  cap_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(cap_fire) |-> lat_col == $past(col_in));
  // R7
  rf_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rfip |-> dram_addr[AW-1:0] == rf_addr);
  // R10
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dram_addr >> AW) == 11'd0);
  // R9
  ft_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_thru |-> bank_q == bank_in);
endmodule

bind dram_addr_mux dram_addr_mux_chk #(.AW(ADDR_W), .BW(BANK_W)) u_chk (.*);

// File: tb/dram_addr_mux_bench.sv
module dram_addr_mux_bench;
  localparam int AW = 10;
  localparam int BW = 2;
  localparam int MAXC = (1 << AW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] row_in = '0, col_in = '0, rf_addr = '0;
  logic [BW-1:0] bank_in = '0;
  logic latch_en = 0, col_phase = 0, rfip = 0, col_inc = 0, fall_thru = 0;
  logic [10:0] dram_addr;
  logic [BW-1:0] bank_q;

  int checks = 0, failures = 0;
  int m_row = 0, m_col = 0, m_bank = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dram_addr_mux #(.ADDR_W(AW), .BANK_W(BW)) u_dram_addr_mux (.*);

  function automatic int exp_addr();
    if (rfip)      return int'(rf_addr);
    if (fall_thru) return col_phase ? int'(col_in) : int'(row_in);
    return col_phase ? m_col : m_row;
  endfunction

  function automatic int exp_bank();
    return fall_thru ? int'(bank_in) : m_bank;
  endfunction

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    if (rst_n && !fall_thru) begin
      if (latch_en) begin
        m_row = int'(row_in); m_col = int'(col_in); m_bank = int'(bank_in);
      end else if (col_inc && !rfip) begin
        m_col = (m_col == MAXC) ? 0 : m_col + 1;
      end
    end
    #5;
  endtask

  task automatic check_all(input string req);
    #1;
    chk(req, int'(dram_addr), exp_addr());
    chk(req, int'(bank_q), exp_bank());
    chk("R10", int'(dram_addr >> AW), 0);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    cyc(); cyc();
    row_in = 10'h155; col_in = 10'h2AA; bank_in = 2'd3;
    #1;
    chk("R1", int'(dram_addr), 0);
    chk("R1", int'(bank_q), 0);
    rst_n = 1'b1;
    // capture
    latch_en = 1; bank_in = 2'd2; cyc();
    latch_en = 0; row_in = 10'h003; bank_in = 2'd1; col_phase = 0; #1;
    chk("R2", int'(dram_addr), 'h155);
    chk("R12", int'(bank_q), 2);
    col_phase = 1; #1;
    chk("R4", int'(dram_addr), 'h2AA);
    col_in = 10'h011; cyc(); #1;
    chk("R3", int'(dram_addr), 'h2AA);
    // increment
    col_inc = 1; cyc(); #1;
    chk("R5", int'(dram_addr), 'h2AB);
    cyc(); #1;
    chk("R5", int'(dram_addr), 'h2AC);
    col_inc = 0;
    // wrap
    col_in = 10'h3FF; row_in = 10'h0F0; latch_en = 1; cyc();
    latch_en = 0; col_inc = 1; cyc(); col_inc = 0; #1;
    chk("R6", int'(dram_addr), 0);
    col_phase = 0; #1;
    chk("R6", int'(dram_addr), 'h0F0);
    // refresh override and ignored increment
    rfip = 1; rf_addr = 10'h1C3; col_phase = 1; col_inc = 1; #1;
    chk("R7", int'(dram_addr), 'h1C3);
    cyc(); cyc();
    rfip = 0; col_inc = 0; #1;
    chk("R8", int'(dram_addr), 0);
    // capture beats increment
    col_in = 10'h100; latch_en = 1; col_inc = 1; cyc();
    latch_en = 0; col_inc = 0; #1;
    chk("R11", int'(dram_addr), 'h100);
    // fall-through
    fall_thru = 1; col_in = 10'h2C1; bank_in = 2'd3; #1;
    chk("R9", int'(dram_addr), 'h2C1);
    chk("R9", int'(bank_q), 3);
    col_phase = 0; row_in = 10'h07E; #1;
    chk("R9", int'(dram_addr), 'h07E);
    fall_thru = 0;
    // constrained random
    void'($urandom(32'd1234));
    for (int i = 0; i < 400; i++) begin
      row_in    = AW'($urandom);
      col_in    = ($urandom % 8 == 0) ? AW'(MAXC) : AW'($urandom);
      bank_in   = BW'($urandom);
      rf_addr   = AW'($urandom);
      latch_en  = ($urandom % 4 == 0);
      col_inc   = ($urandom % 2 == 0);
      rfip      = ($urandom % 5 == 0);
      fall_thru = ($urandom % 8 == 0);
      col_phase = ($urandom % 2 == 0);
      check_all("R3 R4 R5 random");
      cyc();
      check_all("R2 R12 random");
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule